// File: doc/BRIEF.md
# HDLC Frame Receiver

This block recovers frames from a synchronous serial line. The line is sampled on each clock cycle in which the receive bit-enable is high. A run-length monitor watches the raw stream and does three things. It finds the flag pattern that opens and closes a frame. It deletes the zero that the transmitter inserted after five ones. It spots the abort pattern of seven ones in a row. The monitor only counts ones, so a stuffed zero is removed wherever it falls relative to byte boundaries.

Bits that survive zero deletion go through a seven-bit tail buffer. The first seven bits of a closing flag are accepted before the flag can be recognised, and the tail buffer lets them be discarded. Bits that leave the buffer are frame content. They update a reflected CCITT CRC-16 (polynomial x^16+x^12+x^5+1, preset to all ones) and are packed into bytes, least significant bit first. Each completed byte waits in a two-byte holding pipeline. A byte is released only when two newer bytes exist behind it, so the frame check sequence never appears on the byte output. At the closing flag an end-of-frame pulse reports a four-bit status word.

Top module: `hdlc_rx`

## Requirements
- R1: A flag is the bit sequence 0,1,1,1,1,1,1,0 in arrival order (the byte 0x7E sent least significant bit first). A flag opens a frame. If at least one content bit came before it, the same flag also closes the frame. Two flags in a row, and any activity before the first flag, give no byte_valid_o and no eof_o.
- R2: Inside a frame, a 0 that follows exactly five 1s is dropped. The ones count ignores byte boundaries.
- R3: Content bits are packed least significant bit first. byte_valid_o is a one-cycle pulse and only occurs in the cycle after a sampled bit. sof_o is high together with the first byte of a frame, and at no other time.
- R4: A frame with N whole content bytes yields max(N-2, 0) bytes on byte_o, in order. The last two bytes, which are the FCS, are never output.
- R5: The CRC is preset at every flag. status_o[0] (crc ok) is 1 exactly when the reflected CRC (0x8408) over all content bits, FCS included, equals the residue 0xF0B8.
- R6: eof_o pulses for one cycle, in the cycle after the edge that samples the final 0 of the closing flag. It fires only if the frame held at least one content bit, and never in the same cycle as byte_valid_o.
- R7: status_o[2] (short) is set when the frame holds fewer than four whole bytes, that is, fewer than two data bytes plus the FCS.
- R8: status_o[3] (non-octet) is set when the number of content bits is not a multiple of eight.
- R9: Seven consecutive 1s inside an open frame abort it. If content bits had arrived, eof_o pulses in the next cycle with status_o = 4'b0010 (bit 1 = aborted). After an abort, all input is ignored until the next flag, and that flag only opens a new frame.
- R10: While rst_ni is low, byte_valid_o, sof_o and eof_o are 0 and no frame is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Sample rxd_i on this edge |
| rxd_i | input | 1 | Serial receive data |
| byte_o | output | 8 | Received data byte |
| byte_valid_o | output | 1 | byte_o valid, one-cycle pulse |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | Frame ended, status_o valid |
| status_o | output | 4 | {non-octet, short, aborted, crc ok} |

## Verification
eof_o is due exactly one clock after the edge that samples the final 0 of a closing flag, or the seventh 1 of an abort. The bench therefore checks eof_o at the falling edge straight after that bit's sampling edge.

A byte is released one clock after the edge that samples the raw bit which pushes the content bit completing the byte two places later out of the tail buffer. Because of this, byte pulses are collected by a falling-edge monitor. bit_en_i is spaced two cycles apart, so every one-cycle pulse is seen exactly once.

Expected bytes, counts and status bits come from the bench's own bit list and its own CRC, compared after each frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  // bit0 crc ok, bit1 aborted, bit2 short, bit3 non-octet
  typedef struct packed {
    logic non_octet;
    logic short_frm;
    logic aborted;
    logic crc_ok;
  } rx_stat_t;
endpackage

// File: rtl/hdlc_rx_linemon.sv
module hdlc_rx_linemon #(
  parameter int RUN_STUFF = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic rxd_i,
  output logic stuff_o,
  output logic flag_o,
  output logic abort_o
);
  localparam int RUN_MAX = RUN_STUFF + 2;
  localparam int RW = $clog2(RUN_MAX + 1);

  logic [RW-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else if (bit_en_i) begin
      if (!rxd_i) ones_q <= '0;
      else if (ones_q != RW'(RUN_MAX)) ones_q <= ones_q + 1'b1;
    end
  end

  assign stuff_o = bit_en_i && !rxd_i && (ones_q == RW'(RUN_STUFF));
  assign flag_o  = bit_en_i && !rxd_i && (ones_q == RW'(RUN_STUFF + 1));
  assign abort_o = bit_en_i &&  rxd_i && (ones_q == RW'(RUN_STUFF + 1));
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h8408,
  parameter logic [15:0] INIT  = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;

  // reflected, one bit per step
  always_comb begin
    crc_nxt = crc_q >> 1;
    if (crc_q[0] ^ bit_i) crc_nxt = crc_nxt ^ CRC_W'(POLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_W'(INIT);
    else if (init_i) crc_q <= CRC_W'(INIT);
    else if (en_i)   crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hdlc_rx_hold.sv
module hdlc_rx_hold #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic              emit_o,
  output logic [BYTE_W-1:0] dout_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] slot_q [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic              full;

  assign full   = (cnt_q == CW'(DEPTH));
  assign emit_o = push_i && full;
  assign dout_o = slot_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (push_i && !full)   cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q[i] <= '0;
        else if (push_i && (full || cnt_q == CW'(i))) slot_q[i] <= din_i;
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q[i] <= '0;
        else if (push_i) begin
          if (full)                   slot_q[i] <= slot_q[i+1];
          else if (cnt_q == CW'(i))   slot_q[i] <= din_i;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx #(
  parameter int          BYTE_W      = 8,
  parameter int          RUN_STUFF   = 5,
  parameter int          HOLD_BYTES  = 2,
  parameter int          MIN_DATA    = 2,
  parameter int          CRC_W       = 16,
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rxd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic [3:0]        status_o
);
  import hdlc_rx_pkg::*;

  localparam int TAIL      = RUN_STUFF + 2;     // flag bits accepted before the flag is seen
  localparam int TW        = $clog2(TAIL + 1);
  localparam int PW        = $clog2(BYTE_W);
  localparam int SHORT_MIN = HOLD_BYTES + MIN_DATA;
  localparam int NW        = $clog2(SHORT_MIN + 1);

  logic stuff, flag, abort, frame_end;
  logic open_q, any_q, sof_pend_q;
  logic [TAIL-1:0]   dly_q;
  logic [TW-1:0]     dly_cnt_q;
  logic [BYTE_W-1:0] sh_q, byte_nxt;
  logic [PW-1:0]     ph_q;
  logic [NW-1:0]     nbyte_q;
  logic accept, real_vld, real_bit, byte_done;
  logic [CRC_W-1:0]  crc;
  logic              emit;
  logic [BYTE_W-1:0] hold_dout;
  rx_stat_t          st_nxt;

  hdlc_rx_linemon #(.RUN_STUFF(RUN_STUFF)) i_linemon (
    .clk_i, .rst_ni, .bit_en_i, .rxd_i,
    .stuff_o(stuff), .flag_o(flag), .abort_o(abort)
  );

  assign frame_end = flag || abort;
  assign accept    = open_q && bit_en_i && !stuff && !frame_end;
  assign real_vld  = accept && (dly_cnt_q == TW'(TAIL));
  assign real_bit  = dly_q[0];
  assign byte_done = real_vld && (ph_q == PW'(BYTE_W - 1));
  assign byte_nxt  = {real_bit, sh_q[BYTE_W-1:1]};

  hdlc_rx_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc (
    .clk_i, .rst_ni, .init_i(frame_end), .en_i(real_vld), .bit_i(real_bit), .crc_o(crc)
  );

  hdlc_rx_hold #(.BYTE_W(BYTE_W), .DEPTH(HOLD_BYTES)) i_hold (
    .clk_i, .rst_ni, .clr_i(frame_end), .push_i(byte_done), .din_i(byte_nxt),
    .emit_o(emit), .dout_o(hold_dout)
  );

  always_comb begin
    st_nxt = '0;
    if (abort) st_nxt.aborted = 1'b1;
    else begin
      st_nxt.crc_ok    = (crc == CRC_W'(CRC_RESIDUE));
      st_nxt.short_frm = (nbyte_q < NW'(SHORT_MIN));
      st_nxt.non_octet = (ph_q != '0);
    end
  end

  // frame state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0; any_q <= 1'b0; sof_pend_q <= 1'b1;
      dly_q <= '0; dly_cnt_q <= '0; sh_q <= '0; ph_q <= '0; nbyte_q <= '0;
    end else if (frame_end) begin
      open_q <= flag; any_q <= 1'b0; sof_pend_q <= 1'b1;
      dly_cnt_q <= '0; ph_q <= '0; nbyte_q <= '0;
    end else begin
      if (emit) sof_pend_q <= 1'b0;
      if (accept) begin
        dly_q <= {rxd_i, dly_q[TAIL-1:1]};
        if (dly_cnt_q != TW'(TAIL)) dly_cnt_q <= dly_cnt_q + 1'b1;
      end
      if (real_vld) begin
        sh_q  <= byte_nxt;
        any_q <= 1'b1;
        ph_q  <= (ph_q == PW'(BYTE_W - 1)) ? '0 : ph_q + 1'b1;
        if (byte_done && nbyte_q != NW'(SHORT_MIN)) nbyte_q <= nbyte_q + 1'b1;
      end
    end
  end

  // outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0; byte_valid_o <= 1'b0; sof_o <= 1'b0; eof_o <= 1'b0; status_o <= '0;
    end else begin
      byte_valid_o <= emit;
      sof_o        <= emit && sof_pend_q;
      eof_o        <= frame_end && open_q && any_q;
      if (emit) byte_o <= hold_dout;
      if (frame_end && open_q && any_q) status_o <= 4'(st_nxt);
    end
  end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       rxd_i,
  input logic       byte_valid_o,
  input logic       sof_o,
  input logic       eof_o,
  input logic [3:0] status_o
);
  // R6
  eof_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eof_o && byte_valid_o));

  // R3
  sof_with_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_valid_o);

  // R3
  byte_after_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(bit_en_i));

  // R3
  byte_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  // R6
  close_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o && !status_o[1]) |-> ($past(bit_en_i) && !$past(rxd_i)));

  // R9
  abort_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o && status_o[1]) |-> (status_o == 4'b0010 && $past(rxd_i) && $past(bit_en_i)));
endmodule

bind hdlc_rx hdlc_rx_chk i_hdlc_rx_chk (.*);

// File: tb/test_hdlc_rx.sv
module test_hdlc_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic rxd = 1'b1;
  logic [7:0] byte_o;
  logic byte_valid_o, sof_o, eof_o;
  logic [3:0] status_o;

  always #10 clk = ~clk;

  hdlc_rx i_hdlc_rx (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .rxd_i(rxd),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .sof_o(sof_o),
    .eof_o(eof_o), .status_o(status_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit rb [0:2047];
  int rb_n = 0;
  int run = 0;
  logic [7:0] got_b [0:255];
  bit got_sof [0:255];
  int got_n = 0, eof_cnt = 0;
  logic [3:0] got_st;

  always @(negedge clk) begin
    if (byte_valid_o && got_n < 256) begin
      got_b[got_n] = byte_o; got_sof[got_n] = sof_o; got_n++;
    end
    if (eof_o) begin eof_cnt++; got_st = status_o; end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); rxd = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(0);
    for (int i = 0; i < 6; i++) send_bit(1);
    send_bit(0);
    run = 0;
  endtask

  task automatic send_stuffed(bit b);
    send_bit(b);
    if (b) begin
      run++;
      if (run == 5) begin send_bit(0); run = 0; end
    end else run = 0;
  endtask

  task automatic push_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) begin rb[rb_n] = v[i]; rb_n++; end
  endtask

  function automatic logic [15:0] bench_crc();
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < rb_n; i++)
      c = (c >> 1) ^ (((c[0] ^ rb[i]) != 1'b0) ? 16'h8408 : 16'h0000);
    return c;
  endfunction

  task automatic add_fcs(logic [15:0] flip);
    logic [15:0] f;
    f = ~bench_crc() ^ flip;
    push_byte(f[7:0]); push_byte(f[15:8]);
  endtask

  task automatic clear_obs();
    @(posedge clk); got_n = 0; eof_cnt = 0; got_st = 'x;
  endtask

  // send opening flag, stuffed content of rb, closing flag; compare
  task automatic run_frame(string req);
    int nbytes, exp_emit;
    logic [3:0] exp_st;
    logic [7:0] eb;
    clear_obs();
    send_flag();
    run = 0;
    for (int i = 0; i < rb_n; i++) send_stuffed(rb[i]);
    send_flag();
    check(eof_o == (rb_n > 0), "R6", {req, " eof timing"}, eof_o, rb_n > 0);
    @(posedge clk);
    nbytes = rb_n / 8;
    exp_emit = (nbytes > 2) ? nbytes - 2 : 0;
    check(got_n == exp_emit, "R4", {req, " byte count"}, got_n, exp_emit);
    for (int i = 0; i < exp_emit && i < got_n; i++) begin
      for (int k = 0; k < 8; k++) eb[k] = rb[8*i+k];
      check(got_b[i] == eb, "R3", {req, " byte value"}, got_b[i], eb);
      check(got_sof[i] == (i == 0), "R3", {req, " sof"}, got_sof[i], i == 0);
    end
    check(eof_cnt == (rb_n > 0 ? 1 : 0), "R6", {req, " eof count"}, eof_cnt, rb_n > 0);
    if (rb_n > 0) begin
      exp_st = {(rb_n % 8) != 0, nbytes < 4, 1'b0, bench_crc() == 16'hF0B8};
      check(got_st == exp_st, "R5 R7 R8", {req, " status"}, got_st, exp_st);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ab [5];
    repeat (3) @(negedge clk);
    // R10
    check(byte_valid_o == 0 && sof_o == 0 && eof_o == 0, "R10", "reset outputs",
          {byte_valid_o, sof_o, eof_o}, 0);
    rst_n = 1'b1;

    // R1: idle ones and repeated flags give nothing
    clear_obs();
    for (int i = 0; i < 12; i++) send_bit(1);
    repeat (3) send_flag();
    @(posedge clk);
    check(got_n == 0 && eof_cnt == 0, "R1", "back-to-back flags", got_n + eof_cnt, 0);

    // R4 R5 R7: length and pattern sweep, R2 via all-ones and flag-valued data
    for (int len = 0; len <= 6; len++)
      for (int pat = 0; pat < 4; pat++) begin
        rb_n = 0;
        for (int i = 0; i < len; i++)
          case (pat)
            0: push_byte(8'((i * 91 + len * 7 + 3) & 255));
            1: push_byte(8'hFF);
            2: push_byte(8'h7E);
            default: push_byte(8'((i * 37 + 200) & 255) | 8'h1F);
          endcase
        add_fcs(16'h0);
        run_frame("R4 sweep");
      end

    // R2: ones runs straddling byte boundaries
    rb_n = 0;
    push_byte(8'hF0); push_byte(8'h1F); push_byte(8'h3E); push_byte(8'hF8);
    add_fcs(16'h0);
    run_frame("R2 straddle");

    // R3 R5: every byte value as first data byte
    for (int v = 0; v < 256; v++) begin
      rb_n = 0;
      push_byte(8'(v)); push_byte(8'(v) ^ 8'hA5);
      add_fcs(16'h0);
      run_frame("R3 value sweep");
    end

    // R5: corrupted FCS
    rb_n = 0;
    push_byte(8'h12); push_byte(8'h34); push_byte(8'h56);
    add_fcs(16'h0100);
    run_frame("R5 bad fcs");

    // R8: non-octet lengths
    for (int n = 27; n <= 45; n += 18) begin
      rb_n = 0;
      for (int i = 0; i < n; i++) begin rb[rb_n] = ((i * 5 + 1) % 3) == 0; rb_n++; end
      run_frame("R8 non-octet");
    end

    // R9: abort
    ab[0] = 8'h11; ab[1] = 8'h22; ab[2] = 8'h33; ab[3] = 8'h44; ab[4] = 8'h55;
    clear_obs();
    send_flag();
    for (int i = 0; i < 5; i++)
      for (int k = 0; k < 8; k++) send_stuffed(ab[i][k]);
    for (int i = 0; i < 7; i++) send_bit(1);
    check(eof_o == 1, "R9", "abort eof timing", eof_o, 1);
    @(posedge clk);
    check(eof_cnt == 1, "R9", "abort eof count", eof_cnt, 1);
    check(got_st == 4'b0010, "R9", "abort status", got_st, 4'b0010);
    check(got_n == 2, "R9", "abort byte count", got_n, 2);
    check(got_b[0] == 8'h11 && got_b[1] == 8'h22, "R9", "abort bytes",
          {got_b[0], got_b[1]}, 16'h1122);
    // input after abort is ignored; following flag only opens
    clear_obs();
    for (int i = 0; i < 24; i++) send_bit(((24'h5A5A5A >> i) & 1) != 0);
    send_flag();
    check(eof_o == 0, "R9", "flag after abort closes nothing", eof_o, 0);
    @(posedge clk);
    check(got_n == 0 && eof_cnt == 0, "R9", "ignored after abort", got_n + eof_cnt, 0);
    rb_n = 0;
    push_byte(8'hC3); push_byte(8'h3C); push_byte(8'h99);
    add_fcs(16'h0);
    run_frame("R9 recovery");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule